// File: doc/BRIEF.md
# DDR Serial Word Aligner

This block turns a serial double-data-rate sample stream into byte-aligned parallel words. It sits in the bit-clock domain. On every bit-clock cycle it receives two bits of the data lane: one captured on the rising edge and one captured on the falling edge. It receives two bits of the frame lane, captured the same way. Each sample is 8 bits long and the bit clock runs at four times the sample rate, so one word spans four bit-clock cycles.

The bit position of the word boundary is unknown after power-up. The frame lane is captured like a data lane, and it is used as the alignment reference. A correctly framed word reads `11110000`. Every four cycles the block compares the frame word taken at its current bit offset against that pattern. On a mismatch it slips the offset by one bit. After sixteen matching frame words in a row it declares lock. While locked it emits the data word taken at the same offset, together with a one-cycle valid strobe. Three mismatching frame words in a row drop the lock and restart the search.

Top module: `ddr_word_aligner`

## Requirements
- R1: The rising-edge bit of a cycle comes before the falling-edge bit of the same cycle in serial order. The first serial bit of a word appears on `word_o[7]` and the last on `word_o[0]`.
- R2: While `rst_ni` is low, `word_o`, `word_valid_o`, `locked_o` and `search_err_o` are all 0.
- R3: Lock requires 16 consecutive frame words equal to 8'hF0. No lock is possible within the first 60 cycles after reset. For any correctly framed stream, lock is reached within 200 cycles.
- R4: While searching, each mismatching frame word advances the bit offset by exactly one position. The offset wraps from 7 to 0.
- R5: If the frame words at all 8 offsets mismatch, `search_err_o` goes high and the search restarts at offset 0. With no frame pattern present, the flag is still low 20 cycles after reset and is high 40 cycles after reset. It clears when lock is reached, and it is never high while `locked_o` is high.
- R6: While locked, `word_valid_o` pulses for exactly one cycle every 4 cycles. Each strobed `word_o` is the true sample, so consecutive strobed words follow the transmitted sample sequence.
- R7: `word_valid_o` stays low whenever lock was not held in the previous cycle.
- R8: Two consecutive mismatching frame words leave the lock in place, including when two such pairs are separated by one good word. Three consecutive mismatching words clear `locked_o`, and the block then locks again.
- R9: Lock and correct words are reached for initial bit shifts of 0, 3, 5 and 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_rise_i | input | 1 | Data lane bit captured on the rising edge |
| data_fall_i | input | 1 | Data lane bit captured on the falling edge |
| frame_rise_i | input | 1 | Frame lane bit captured on the rising edge |
| frame_fall_i | input | 1 | Frame lane bit captured on the falling edge |
| word_o | output | 8 | Aligned sample word, first serial bit in the MSB |
| word_valid_o | output | 1 | One-cycle strobe marking a new aligned word |
| locked_o | output | 1 | Word alignment is locked |
| search_err_o | output | 1 | A full sweep of offsets found no frame match |

## Verification
Some behaviours are checked by assertions on every cycle:
- The valid strobe is one cycle wide and follows a cycle of held lock.
- The error and lock flags are never high together.
- The offset moves only on a word strobe, and only by a single step or a wrap to zero.
- The error flag rises only on that wrap.
- Lock is gained only on a matching frame word and lost only on a mismatching one.

Other behaviours can only be shown by the bench scenarios:
- Whether the recovered words are the real samples for each initial shift.
- Lock timing bounds.
- Error-flag timing with a dead frame lane.
- Tolerance of paired bad frame words versus loss of lock on a run of three.

// File: rtl/ddr_align_pkg.sv
package ddr_align_pkg;
  typedef enum logic {
    ST_SEARCH = 1'b0,
    ST_LOCKED = 1'b1
  } align_st_e;
endpackage

// File: rtl/ddr_deser.sv
module ddr_deser #(
  parameter int WORD_W = 8,
  localparam int HIST_W = 2 * WORD_W - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rise_i,
  input  logic              fall_i,
  output logic [HIST_W-1:0] hist_o
);
  // index 0 is the newest bit; rise precedes fall in serial order
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hist_o <= '0;
    else         hist_o <= {hist_o[HIST_W-3:0], rise_i, fall_i};
  end
endmodule

// File: rtl/word_phase.sv
module word_phase #(
  parameter int WORD_W = 8,
  localparam int CYC   = WORD_W / 2,
  localparam int PH_W  = (CYC > 1) ? $clog2(CYC) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic strobe_o
);
  logic [PH_W-1:0] ph_q;

  assign strobe_o = (ph_q == PH_W'(CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ph_q <= '0;
    else if (strobe_o) ph_q <= '0;
    else               ph_q <= ph_q + 1'b1;
  end
endmodule

// File: rtl/bit_selector.sv
module bit_selector #(
  parameter int WORD_W = 8,
  localparam int HIST_W = 2 * WORD_W - 1,
  localparam int OFF_W  = $clog2(WORD_W)
) (
  input  logic [HIST_W-1:0] hist_i,
  input  logic [OFF_W-1:0]  off_i,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] cand [WORD_W];

  for (genvar gi = 0; gi < WORD_W; gi++) begin : g_cand
    assign cand[gi] = hist_i[gi +: WORD_W];
  end

  assign word_o = cand[off_i];
endmodule

// File: rtl/align_fsm.sv
module align_fsm
  import ddr_align_pkg::*;
#(
  parameter int              WORD_W     = 8,
  parameter int              LOCK_WORDS = 16,
  parameter int              LOSS_WORDS = 3,
  parameter logic [WORD_W-1:0] FRAME_PAT = 8'hF0,
  localparam int OFF_W  = $clog2(WORD_W),
  localparam int MCNT_W = $clog2(LOCK_WORDS + 1),
  localparam int LCNT_W = $clog2(LOSS_WORDS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strobe_i,
  input  logic [WORD_W-1:0] frame_word_i,
  output logic [OFF_W-1:0]  off_o,
  output logic              locked_o,
  output logic              err_o
);
  align_st_e         st_q;
  logic [MCNT_W-1:0] match_q;
  logic [LCNT_W-1:0] miss_q;
  logic              hit;

  assign hit      = (frame_word_i == FRAME_PAT);
  assign locked_o = (st_q == ST_LOCKED);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_SEARCH;
      match_q <= '0;
      miss_q  <= '0;
      off_o   <= '0;
      err_o   <= 1'b0;
    end else if (strobe_i) begin
      case (st_q)
        ST_SEARCH: begin
          if (hit) begin
            if (match_q == MCNT_W'(LOCK_WORDS - 1)) begin
              st_q    <= ST_LOCKED;
              match_q <= '0;
              miss_q  <= '0;
              err_o   <= 1'b0;
            end else begin
              match_q <= match_q + 1'b1;
            end
          end else begin
            match_q <= '0;
            if (off_o == OFF_W'(WORD_W - 1)) begin
              off_o <= '0;
              err_o <= 1'b1;   // every offset tried
            end else begin
              off_o <= off_o + 1'b1;
            end
          end
        end
        default: begin
          if (hit) begin
            miss_q <= '0;
          end else if (miss_q == LCNT_W'(LOSS_WORDS - 1)) begin
            st_q   <= ST_SEARCH;
            off_o  <= '0;
            miss_q <= '0;
          end else begin
            miss_q <= miss_q + 1'b1;
          end
        end
      endcase
    end
  end

  // R4
  off_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(off_o) |-> $past(strobe_i) &&
      (off_o == OFF_W'($past(off_o) + 1'b1) || off_o == '0));
  // R5
  err_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> off_o == '0 && $past(off_o) == OFF_W'(WORD_W - 1));
  // R3
  lock_on_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_o) |-> $past(strobe_i && hit));
  // R8
  loss_on_miss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(locked_o) |-> $past(strobe_i && !hit));
endmodule

// File: rtl/ddr_word_aligner.sv
module ddr_word_aligner #(
  parameter int WORD_W     = 8,
  parameter int LOCK_WORDS = 16,
  parameter int LOSS_WORDS = 3,
  localparam int HIST_W = 2 * WORD_W - 1,
  localparam int OFF_W  = $clog2(WORD_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              data_rise_i,
  input  logic              data_fall_i,
  input  logic              frame_rise_i,
  input  logic              frame_fall_i,
  output logic [WORD_W-1:0] word_o,
  output logic              word_valid_o,
  output logic              locked_o,
  output logic              search_err_o
);
  logic [HIST_W-1:0] data_hist, frame_hist;
  logic [WORD_W-1:0] data_word, frame_word;
  logic [OFF_W-1:0]  off;
  logic              strobe;

  ddr_deser #(.WORD_W(WORD_W)) i_data_deser (
    .clk_i, .rst_ni, .rise_i(data_rise_i), .fall_i(data_fall_i), .hist_o(data_hist));

  ddr_deser #(.WORD_W(WORD_W)) i_frame_deser (
    .clk_i, .rst_ni, .rise_i(frame_rise_i), .fall_i(frame_fall_i), .hist_o(frame_hist));

  word_phase #(.WORD_W(WORD_W)) i_phase (
    .clk_i, .rst_ni, .strobe_o(strobe));

  bit_selector #(.WORD_W(WORD_W)) i_data_sel (
    .hist_i(data_hist), .off_i(off), .word_o(data_word));

  bit_selector #(.WORD_W(WORD_W)) i_frame_sel (
    .hist_i(frame_hist), .off_i(off), .word_o(frame_word));

  align_fsm #(
    .WORD_W(WORD_W), .LOCK_WORDS(LOCK_WORDS), .LOSS_WORDS(LOSS_WORDS)
  ) i_fsm (
    .clk_i, .rst_ni, .strobe_i(strobe), .frame_word_i(frame_word),
    .off_o(off), .locked_o(locked_o), .err_o(search_err_o));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_o       <= '0;
      word_valid_o <= 1'b0;
    end else begin
      word_valid_o <= strobe && locked_o;
      if (strobe) word_o <= data_word;
    end
  end

  // R6
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |=> !word_valid_o);
  // R7
  valid_needs_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |-> $past(locked_o));
  // R5
  err_lock_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(search_err_o && locked_o));
endmodule

// File: tb/test_ddr_word_aligner.sv
module test_ddr_word_aligner;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       d_r = 1'b0, d_f = 1'b0, f_r = 1'b0, f_f = 1'b0;
  logic [7:0] word_o;
  logic       word_valid_o, locked_o, search_err_o;

  int checks = 0, failures = 0;
  int g = 0, shift = 0;
  bit frame_dead = 0;
  int bad_a = -100, bad_an = 0, bad_b = -100, bad_bn = 0;
  bit mon_en = 0, have_prev = 0;
  logic [7:0] prev_w;
  int since_v = 0, n_valid = 0;

  always #4 clk = ~clk;

  ddr_word_aligner i_ddr_word_aligner (
    .clk_i(clk), .rst_ni(rst_n),
    .data_rise_i(d_r), .data_fall_i(d_f),
    .frame_rise_i(f_r), .frame_fall_i(f_f),
    .word_o(word_o), .word_valid_o(word_valid_o),
    .locked_o(locked_o), .search_err_o(search_err_o));

  function automatic logic [7:0] sample(int w);
    return 8'(w * 29 + 7);
  endfunction

  function automatic int word_of(int n);
    return (n + 8 - shift) / 8;
  endfunction

  // R1: serial bit p of a word is sample bit 7-p
  function automatic logic data_bit(int n);
    int m = n + 8 - shift;
    logic [7:0] s = sample(m / 8);
    return s[7 - (m % 8)];
  endfunction

  function automatic logic frame_bit(int n);
    int m = n + 8 - shift;
    int w = m / 8;
    bit bad = (w >= bad_a && w < bad_a + bad_an) || (w >= bad_b && w < bad_b + bad_bn);
    return ((m % 8) < 4) && !bad && !frame_dead;
  endfunction

  always @(negedge clk) begin
    d_r <= data_bit(g);
    d_f <= data_bit(g + 1);
    f_r <= frame_bit(g);
    f_f <= frame_bit(g + 1);
    g   <= g + 2;
  end

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R6 monitor: strobe spacing and sample sequence while locked
  always @(negedge clk) begin
    since_v++;
    if (mon_en && word_valid_o) begin
      n_valid++;
      if (have_prev) begin
        check(word_o == 8'(prev_w + 8'd29), "R6 word", word_o, 8'(prev_w + 8'd29));
        check(since_v == 4, "R6 spacing", since_v, 4);
      end
      have_prev = 1;
      prev_w    = word_o;
      since_v   = 0;
    end
    if (!locked_o && !word_valid_o) have_prev = 0;
  end

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(int sh);
    mon_en = 0; have_prev = 0; n_valid = 0;
    frame_dead = 0; bad_an = 0; bad_bn = 0;
    shift = sh;
    rst_n = 0;
    cycles(3);
    check(word_o == 0 && !word_valid_o && !locked_o && !search_err_o, "R2 reset",
          {word_o, word_valid_o, locked_o, search_err_o}, 0);
    rst_n = 1;
  endtask

  task automatic wait_lock(int limit);
    for (int i = 0; i < limit && !locked_o; i++) @(negedge clk);
  endtask

  task automatic t_lock(int sh);
    bit early_bad = 0;
    do_reset(sh);
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (locked_o || word_valid_o) early_bad = 1;
    end
    check(!early_bad, "R3/R7 no early lock or valid", early_bad, 0);
    wait_lock(140);
    check(locked_o, "R9 lock reached", locked_o, 1);
    mon_en = 1;
    cycles(60);
    check(n_valid >= 14, "R6 valid count", n_valid, 14);
    check(!search_err_o, "R5 err clear when locked", search_err_o, 0);
  endtask

  task automatic t_no_frame();
    do_reset(2);
    frame_dead = 1;
    cycles(20);
    check(!search_err_o, "R5 err not yet", search_err_o, 0);
    cycles(20);
    check(search_err_o && !locked_o, "R5 err after sweep", search_err_o, 1);
    frame_dead = 0;
    wait_lock(200);
    check(locked_o, "R5 lock after restart", locked_o, 1);
    check(!search_err_o, "R5 err cleared on lock", search_err_o, 0);
  endtask

  task automatic t_loss();
    int cw;
    do_reset(5);
    wait_lock(200);
    check(locked_o, "R8 initial lock", locked_o, 1);
    mon_en = 1;
    cw = word_of(g);
    bad_a = cw + 3; bad_an = 2;
    cycles(50);
    check(locked_o, "R8 two bad words keep lock", locked_o, 1);
    cw = word_of(g);
    bad_a = cw + 3; bad_an = 2; bad_b = cw + 6; bad_bn = 2;
    cycles(60);
    check(locked_o, "R8 split bad pairs keep lock", locked_o, 1);
    bad_bn = 0;
    cw = word_of(g);
    bad_a = cw + 2; bad_an = 3;
    cycles(36);
    check(!locked_o, "R8 three bad words drop lock", locked_o, 0);
    wait_lock(200);
    check(locked_o, "R8 relock", locked_o, 1);
    n_valid = 0;
    cycles(40);
    check(n_valid >= 9, "R6 valid after relock", n_valid, 9);
  endtask

  initial begin
    #(8 * 100000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_lock(0);
    t_lock(3);
    t_lock(5);
    t_lock(7);
    t_no_frame();
    t_loss();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule